// File: doc/BRIEF.md
# Heap Block Tag Guard

This block gives every word of a small data memory a block identifier tag and checks, on every load and store, that the tag carried by the pointer matches the tag held by the addressed word. Software asks for an allocation by giving a base word address and a length in words. The block hands out a fresh identifier, stamps it onto every word of the range in hardware, and returns it so that it can travel with the pointer. Freeing a range stamps the reserved tag 0 onto every word of it. Any later access through the old pointer then fails, so out-of-bounds accesses and uses after free are both caught.

Tag stamping runs in a fill engine that writes one word per cycle. While it runs, the block lowers `ready` and accepts neither commands nor accesses. Identifiers come from an ascending counter. Once the largest identifier has been handed out, further allocations are refused and a sticky error is raised rather than reusing an identifier.

Top module: `heap_tag_guard`

## Requirements
- R1: An allocate command (`cmd_op` = 2'b01) accepted while `ready` is high pulses `alloc_done` for one cycle on the next cycle, with `alloc_tag` holding the identifier. Identifiers start at 1 after reset and rise by one with every granted allocation, including allocations of length 0. Codes 2'b00 and 2'b11 do nothing.
- R2: A granted allocation of length L (0 to 256) tags words base, base+1, ..., base+L-1 with its identifier. Addresses wrap modulo 256.
- R3: A free command (`cmd_op` = 2'b10) rewrites the tag of every word in its range to 0.
- R4: An access accepted while `ready` is high gives `resp_valid` on the next cycle. `resp_fault` is 0 only when the pointer tag is nonzero and equals the word's tag. `resp_rdata` carries the word's data for an allowed read and 0 otherwise.
- R5: After a range is freed, an access with the tag it was allocated under faults, and so does an access with a stale tag after the range has been allocated again.
- R6: After a command of length L > 0, `ready` stays low for exactly L cycles, since one word is tagged per cycle. Accesses and commands presented while `ready` is low are not accepted and produce no response.
- R7: A store that faults changes neither the data nor the tag of the addressed word. An allowed store changes only the data.
- R8: Once identifier 16'hFFFF has been granted, every further allocation pulses `alloc_refused`, tags no word and sets `id_wrap_err`, which stays high until reset.
- R9: After reset, every word has tag 0 and data 0, `ready` is high, and `id_wrap_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 allocate, 10 free, others ignored |
| cmd_base | input | 8 | First word address of the range |
| cmd_len | input | 9 | Range length in words, 0 to 256 |
| ready | output | 1 | High when commands and accesses can be accepted |
| alloc_done | output | 1 | One-cycle pulse: allocation granted |
| alloc_tag | output | 16 | Identifier of the last granted allocation |
| alloc_refused | output | 1 | One-cycle pulse: allocation refused, identifiers used up |
| id_wrap_err | output | 1 | Sticky: an allocation was refused |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 store, 0 load |
| acc_addr | input | 8 | Word address |
| acc_ptr_tag | input | 16 | Tag carried by the pointer |
| acc_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Access response |
| resp_fault | output | 1 | Access rejected |
| resp_rdata | output | 32 | Load data, 0 on fault or store |

## Verification
A wrong tag left in the store shows only when the word is next touched: a load through the right pointer then faults on the cycle after it is accepted, or a load through a stale pointer succeeds. The bench therefore reads every word of interest after each fill. A fill engine that runs short or long shows at once as a `ready` low time that differs from the length, and a wrong identifier counter shows on the next `alloc_tag`. The faulting-store and refused-allocation cases are observed by later loads through valid pointers, which expose any data or tag the design should have left alone.

// File: rtl/htg_pkg.sv
package htg_pkg;
   localparam logic [1:0] OP_ALLOC = 2'b01;
   localparam logic [1:0] OP_FREE  = 2'b10;

   function automatic logic tag_allows(input logic [15:0] ptr_tag, input logic [15:0] cell_tag);
      return (ptr_tag != '0) && (ptr_tag == cell_tag);
   endfunction
endpackage

// File: rtl/htg_id_alloc.sv
module htg_id_alloc #(
   parameter int TAG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   output logic             grant_o,
   output logic [TAG_W-1:0] id_o
);
   localparam logic [TAG_W-1:0] FIRST_ID = TAG_W'(1);
   localparam logic [TAG_W-1:0] LAST_ID  = '1;

   if (TAG_W < 2) begin : g_bad_tag_w
      $error("htg_id_alloc: TAG_W must be at least 2");
   end

   logic [TAG_W-1:0] next_q;
   logic             spent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q  <= FIRST_ID;
         spent_q <= 1'b0;
      end else if (take_i && !spent_q) begin
         if (next_q == LAST_ID) spent_q <= 1'b1;
         else                   next_q  <= next_q + 1'b1;
      end
   end

   assign grant_o = !spent_q;
   assign id_o    = next_q;

   // R1: a granted identifier is never the reserved tag
   p_id_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> id_o != '0);
endmodule

// File: rtl/htg_fill_engine.sv
module htg_fill_engine #(
   parameter int ADDR_W = 8,
   parameter int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W:0]   len_i,
   input  logic [TAG_W-1:0]  tag_i,
   output logic              busy_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [TAG_W-1:0]  wr_tag_o
);
   localparam int LEN_W = ADDR_W + 1;

   logic [ADDR_W-1:0] cur_q;
   logic [LEN_W-1:0]  left_q;
   logic [TAG_W-1:0]  tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         left_q <= '0;
         tag_q  <= '0;
      end else if (start_i && (len_i != '0)) begin
         cur_q  <= base_i;
         left_q <= len_i;
         tag_q  <= tag_i;
      end else if (left_q != '0) begin
         cur_q  <= cur_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign busy_o    = (left_q != '0);
   assign wr_en_o   = busy_o;
   assign wr_addr_o = cur_q;
   assign wr_tag_o  = tag_q;

   // R2: consecutive fill writes walk the range one word at a time
   p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o && $past(wr_en_o) |-> wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1));
   // R6: a new fill is never loaded over a running one
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i);
endmodule

// File: rtl/htg_tag_mem.sv
module htg_tag_mem #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f_we_i,
   input  logic [ADDR_W-1:0] f_addr_i,
   input  logic [TAG_W-1:0]  f_tag_i,
   input  logic              a_we_i,
   input  logic [ADDR_W-1:0] a_addr_i,
   input  logic [DATA_W-1:0] a_wdata_i,
   output logic [TAG_W-1:0]  a_tag_o,
   output logic [DATA_W-1:0] a_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else begin
         if (f_we_i) tag_q[f_addr_i]  <= f_tag_i;
         if (a_we_i) data_q[a_addr_i] <= a_wdata_i;
      end
   end

   assign a_tag_o  = tag_q[a_addr_i];
   assign a_data_o = data_q[a_addr_i];

   // R6: a fill write and an access store never share a cycle
   p_port_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_we_i && a_we_i));
endmodule

// File: rtl/htg_access_check.sv
module htg_access_check #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic              write_i,
   input  logic [TAG_W-1:0]  ptr_tag_i,
   input  logic [TAG_W-1:0]  cell_tag_i,
   input  logic [DATA_W-1:0] cell_data_i,
   output logic              mem_we_o,
   output logic              resp_valid_o,
   output logic              resp_fault_o,
   output logic [DATA_W-1:0] resp_rdata_o
);
   logic allow;

   assign allow    = (ptr_tag_i != '0) && (ptr_tag_i == cell_tag_i);
   assign mem_we_o = fire_i && write_i && allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid_o <= 1'b0;
         resp_fault_o <= 1'b0;
         resp_rdata_o <= '0;
      end else begin
         resp_valid_o <= fire_i;
         resp_fault_o <= fire_i && !allow;
         resp_rdata_o <= (fire_i && allow && !write_i) ? cell_data_i : '0;
      end
   end

   // R4: a pointer carrying the reserved tag is always rejected
   p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid_o && $past(fire_i && (ptr_tag_i == '0)) |-> resp_fault_o);
   // R4: a rejected access returns no data
   p_fault_rdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid_o && resp_fault_o |-> resp_rdata_o == '0);
endmodule

// File: rtl/heap_tag_guard.sv
module heap_tag_guard #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [ADDR_W:0]   cmd_len,
   output logic              ready,
   output logic              alloc_done,
   output logic [TAG_W-1:0]  alloc_tag,
   output logic              alloc_refused,
   output logic              id_wrap_err,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [TAG_W-1:0]  acc_ptr_tag,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              resp_valid,
   output logic              resp_fault,
   output logic [DATA_W-1:0] resp_rdata
);
   import htg_pkg::*;

   localparam logic [TAG_W-1:0] NOREF_TAG = '0;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("heap_tag_guard: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("heap_tag_guard: DATA_W must be positive");
   end

   logic              fill_busy, fill_we, fill_start;
   logic [ADDR_W-1:0] fill_addr;
   logic [TAG_W-1:0]  fill_wtag, fill_tag;
   logic              id_grant;
   logic [TAG_W-1:0]  id_val;
   logic              cmd_fire, is_alloc, is_free, acc_fire;
   logic              mem_we;
   logic [TAG_W-1:0]  cell_tag;
   logic [DATA_W-1:0] cell_data;

   assign ready      = !fill_busy;
   assign cmd_fire   = cmd_valid && ready;
   assign is_alloc   = cmd_fire && (cmd_op == OP_ALLOC);
   assign is_free    = cmd_fire && (cmd_op == OP_FREE);
   assign fill_start = (is_alloc && id_grant) || is_free;
   assign fill_tag   = is_alloc ? id_val : NOREF_TAG;
   assign acc_fire   = acc_valid && ready;

   htg_id_alloc #(.TAG_W(TAG_W)) u_ids (
      .clk(clk), .rst_n(rst_n), .take_i(is_alloc),
      .grant_o(id_grant), .id_o(id_val));

   htg_fill_engine #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .start_i(fill_start), .base_i(cmd_base),
      .len_i(cmd_len), .tag_i(fill_tag), .busy_o(fill_busy),
      .wr_en_o(fill_we), .wr_addr_o(fill_addr), .wr_tag_o(fill_wtag));

   htg_tag_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .f_we_i(fill_we), .f_addr_i(fill_addr), .f_tag_i(fill_wtag),
      .a_we_i(mem_we), .a_addr_i(acc_addr), .a_wdata_i(acc_wdata),
      .a_tag_o(cell_tag), .a_data_o(cell_data));

   htg_access_check #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
      .clk(clk), .rst_n(rst_n), .fire_i(acc_fire), .write_i(acc_write),
      .ptr_tag_i(acc_ptr_tag), .cell_tag_i(cell_tag), .cell_data_i(cell_data),
      .mem_we_o(mem_we), .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
      .resp_rdata_o(resp_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_done    <= 1'b0;
         alloc_tag     <= '0;
         alloc_refused <= 1'b0;
         id_wrap_err   <= 1'b0;
      end else begin
         alloc_done    <= is_alloc && id_grant;
         alloc_refused <= is_alloc && !id_grant;
         if (is_alloc && id_grant) alloc_tag <= id_val;
         if (is_alloc && !id_grant) id_wrap_err <= 1'b1;
      end
   end

   // R6: nothing presented while not ready produces a response
   p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> !resp_valid);
   // R8: a refusal leaves the wrap error raised
   p_refused_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_refused |-> id_wrap_err);
   // R8: the wrap error never clears without reset
   p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      id_wrap_err |=> id_wrap_err);
   // R1: grant and refusal are exclusive
   p_done_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_done && alloc_refused));
endmodule

// File: tb/heap_tag_guard_test.sv
module heap_tag_guard_test;
   localparam int CLK_P = 10;
   localparam int DEPTH = 256;

   logic        clk = 0, rst_n = 0;
   logic        cmd_valid = 0;
   logic [1:0]  cmd_op = 0;
   logic [7:0]  cmd_base = 0;
   logic [8:0]  cmd_len = 0;
   logic        ready, alloc_done, alloc_refused, id_wrap_err;
   logic [15:0] alloc_tag;
   logic        acc_valid = 0, acc_write = 0;
   logic [7:0]  acc_addr = 0;
   logic [15:0] acc_ptr_tag = 0;
   logic [31:0] acc_wdata = 0;
   logic        resp_valid, resp_fault;
   logic [31:0] resp_rdata;

   int checks = 0, errors = 0;
   bit finished = 0;
   int m_tag [DEPTH];
   int m_data [DEPTH];
   int m_next = 1;

   heap_tag_guard uut (.*);

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input int base, input int len, input string req);
      bit granted, is_alloc, is_free;
      int busy_n;
      is_alloc = (op == 2'b01);
      is_free  = (op == 2'b10);
      granted  = is_alloc && (m_next <= 16'hFFFF);
      @(negedge clk);
      while (!ready) @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_base = base[7:0]; cmd_len = len[8:0];
      @(posedge clk); #1;
      chk(alloc_done == granted, req, "alloc_done", alloc_done, granted);
      chk(alloc_refused == (is_alloc && !granted), req, "alloc_refused", alloc_refused, is_alloc && !granted);
      if (granted) chk(alloc_tag == m_next[15:0], req, "alloc_tag", alloc_tag, m_next);
      @(negedge clk);
      cmd_valid = 0;
      busy_n = 0;
      while (!ready) begin busy_n++; @(negedge clk); end
      if (granted || is_free)
         chk(busy_n == len, "R6", "ready low cycles", busy_n, len);
      else
         chk(busy_n == 0, "R6", "ready low cycles", busy_n, 0);
      if (granted || is_free) begin
         for (int i = 0; i < len; i++) m_tag[(base + i) % DEPTH] = granted ? m_next : 0;
      end
      if (granted) m_next++;
   endtask

   task automatic run_acc(input bit wr, input int addr, input int ptr, input int wdata, input string req);
      bit exp_fault;
      int exp_rd;
      exp_fault = (ptr == 0) || (ptr != m_tag[addr]);
      exp_rd = (!exp_fault && !wr) ? m_data[addr] : 0;
      @(negedge clk);
      while (!ready) @(negedge clk);
      acc_valid = 1; acc_write = wr; acc_addr = addr[7:0];
      acc_ptr_tag = ptr[15:0]; acc_wdata = wdata;
      @(posedge clk); #1;
      chk(resp_valid == 1'b1, req, "resp_valid", resp_valid, 1);
      chk(resp_fault == exp_fault, req, "resp_fault", resp_fault, exp_fault);
      chk(resp_rdata == exp_rd, req, "resp_rdata", resp_rdata, exp_rd);
      @(negedge clk);
      acc_valid = 0;
      if (wr && !exp_fault) m_data[addr] = wdata;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      int r;
      int n;
      seed = 32'h5eed_0042;
      r = $urandom(seed);
      for (int i = 0; i < DEPTH; i++) begin m_tag[i] = 0; m_data[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R9 reset state
      chk(ready == 1'b1, "R9", "ready after reset", ready, 1);
      chk(id_wrap_err == 1'b0, "R9", "id_wrap_err after reset", id_wrap_err, 0);
      chk(resp_valid == 1'b0, "R9", "resp_valid after reset", resp_valid, 0);
      run_acc(0, 5, 0, 0, "R9");
      run_acc(0, 5, 1, 0, "R9");

      // R1 R2 basic allocation
      run_cmd(2'b01, 10, 4, "R1");
      for (int a = 9; a <= 14; a++) run_acc(0, a, 1, 0, "R2");
      // R4 stores and loads
      run_acc(1, 11, 1, 32'hCAFE_0011, "R4");
      run_acc(0, 11, 1, 0, "R4");
      run_acc(0, 11, 2, 0, "R4");
      // R7 faulting store changes nothing
      run_acc(1, 11, 2, 32'hBAD0_BAD0, "R7");
      run_acc(1, 11, 0, 32'hBAD0_BAD1, "R7");
      run_acc(0, 11, 1, 0, "R7");
      // R6 long fill
      run_cmd(2'b01, 100, 20, "R6");
      run_acc(0, 119, 2, 0, "R6");
      run_acc(0, 120, 2, 0, "R6");
      // R2 address wrap
      run_cmd(2'b01, 254, 4, "R2");
      for (int a = 0; a < 3; a++) run_acc(0, (254 + a) % DEPTH, 3, 0, "R2");
      run_acc(0, 1, 3, 0, "R2");
      run_acc(0, 2, 3, 0, "R2");
      // ignored opcodes
      run_cmd(2'b00, 10, 4, "R1");
      run_cmd(2'b11, 10, 4, "R1");
      run_acc(0, 11, 1, 0, "R1");
      // R3 R5 free and reuse
      run_cmd(2'b10, 10, 4, "R3");
      run_acc(0, 11, 1, 0, "R5");
      run_acc(0, 12, 0, 0, "R3");
      run_cmd(2'b01, 10, 4, "R5");
      run_acc(0, 11, 1, 0, "R5");
      run_acc(0, 11, 4, 0, "R5");
      // R1 zero length allocation consumes an id
      run_cmd(2'b01, 40, 0, "R1");
      run_acc(0, 40, 5, 0, "R1");
      run_cmd(2'b01, 40, 1, "R1");
      run_acc(0, 40, 6, 0, "R1");
      // full-memory allocation and free
      run_cmd(2'b01, 0, 256, "R2");
      run_acc(0, 200, m_next - 1, 0, "R2");
      run_cmd(2'b10, 0, 256, "R3");
      run_acc(0, 200, m_next - 1, 0, "R3");

      // random mix
      for (int k = 0; k < 300; k++) begin
         r = $urandom % 10;
         if (r < 2) begin
            run_cmd(2'b01, $urandom % DEPTH, $urandom % 9, "R2");
         end else if (r < 3) begin
            run_cmd(2'b10, $urandom % DEPTH, $urandom % 9, "R3");
         end else begin
            int a, p;
            a = $urandom % DEPTH;
            p = ($urandom % 2) ? m_tag[a] : ($urandom % m_next);
            run_acc($urandom % 2, a, p, $urandom, "R4");
         end
      end

      // R8 identifier exhaustion
      n = 16'hFFFE - m_next + 1;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 2'b01; cmd_base = 0; cmd_len = 0;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cmd_valid = 0;
      m_next = 16'hFFFF;
      chk(id_wrap_err == 1'b0, "R8", "id_wrap_err before exhaustion", id_wrap_err, 0);
      run_cmd(2'b01, 60, 2, "R8");
      run_acc(0, 60, 16'hFFFF, 0, "R8");
      run_acc(1, 60, 16'hFFFF, 32'h0000_6060, "R8");
      run_cmd(2'b01, 60, 2, "R8");
      chk(id_wrap_err == 1'b1, "R8", "id_wrap_err after refusal", id_wrap_err, 1);
      run_acc(0, 60, 16'hFFFF, 0, "R8");
      run_acc(0, 61, 16'hFFFF, 0, "R8");
      run_cmd(2'b10, 60, 1, "R8");
      run_acc(0, 60, 16'hFFFF, 0, "R8");
      @(negedge clk);
      chk(id_wrap_err == 1'b1, "R8", "id_wrap_err sticky", id_wrap_err, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule